// File: doc/BRIEF.md
# Configurable Routing Connection Box

The connection box sits in a tile of a coarse-grained reconfigurable array. It chooses one of several routing tracks, or a constant held in its own configuration storage, and drives that choice onto one output bus of parameter width. A build-time feedthrough mask decides which tracks are wired to the multiplexer at all. Tracks whose mask bit is clear are never selectable, and the remaining ones are numbered in ascending track order.

Configuration arrives over a 32-bit write port whose register index sits in the top address byte. The select field starts at configuration bit 0, and the optional constant is packed directly above it. The packed fields may straddle a 32-bit register boundary. A registered readback port returns any configuration register one cycle after a read request. At reset the select field loads a value that, with the constant option on, points at the constant entry.

Top module: `cb_conn_box`

## Requirements
- R1: Multiplexer input k is the track holding the k-th set bit of FEED_MASK, counting up from bit 0. Track t occupies tracks_i[t*WIDTH +: WIDTH].
- R2: The select field is configuration bits [SEL_W-1:0], which are the low bits of register 0. SEL_W is ceil(log2(NUM_IN + HAS_CONST)) with a minimum of 1, and NUM_IN is the number of set mask bits.
- R3: With HAS_CONST=1, the constant occupies configuration bits [SEL_W +: WIDTH]. Configuration bit b is bit b%32 of register b/32, so the constant may continue into the next register.
- R4: A write with cfg_we_i high updates, at the clock edge, the register whose index is cfg_addr_i[31:24]. Address bits 23:0 are ignored, and a write to an index of NUM_REGS or above changes no register.
- R5: Reset loads NUM_TRACKS - (masked-out tracks) + HAS_CONST - 1 into the select field and DEFAULT_CONST into the constant field when HAS_CONST=1. All other configuration bits reset to 0.
- R6: When select < NUM_IN, data_o equals multiplexer input number select in the same cycle.
- R7: When select >= NUM_IN, data_o equals the stored constant with HAS_CONST=1, or zero with HAS_CONST=0.
- R8: After a clock edge with cfg_re_i high, cfg_rdata_o holds the register indexed by cfg_addr_i[31:24], or zero for an index of NUM_REGS or above. A write in that same cycle is not yet visible. cfg_rdata_o holds its value while cfg_re_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_addr_i | input | 32 | Configuration address; bits 31:24 select the register |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_re_i | input | 1 | Configuration read request |
| cfg_rdata_o | output | 32 | Registered readback data |
| tracks_i | input | NUM_TRACKS*WIDTH | Routing track inputs, track t at bits t*WIDTH |
| data_o | output | WIDTH | Selected output |

## Verification
The main instance masks out track 3 and has the constant enabled. Each select value 0 to 3 is driven with distinct track words, so a swapped or unpruned input mapping shows up as the wrong word. Select values 4 to 7 must all give the constant, and the constant is written in two halves across the register boundary, so a misaligned field or a wrong half-word shows up at the output. A second instance without the constant distinguishes the zero fallback from a stale track value. Seeded random writes, including indices 2 and 3 beyond the register file, are compared against a bench model of both registers through the output and through readback.

// File: rtl/cb_conn_pkg.sv
package cb_conn_pkg;
  localparam int CFG_DW  = 32;
  localparam int IDX_W   = 8;
  localparam int IDX_LSB = 24;

  function automatic int count_ones(input logic [63:0] m, input int n);
    int c = 0;
    for (int i = 0; i < 64; i++) if (i < n && m[i]) c++;
    return c;
  endfunction

  // position of the k-th set bit of m among its low n bits
  function automatic int nth_set(input logic [63:0] m, input int n, input int k);
    int seen = 0;
    int pos  = 0;
    for (int i = 0; i < 64; i++) begin
      if (i < n && m[i]) begin
        if (seen == k) pos = i;
        seen++;
      end
    end
    return pos;
  endfunction

  function automatic int sel_width(input int height);
    return (height <= 2) ? 1 : $clog2(height);
  endfunction
endpackage

// File: rtl/cb_cfg_regs.sv
module cb_cfg_regs
  import cb_conn_pkg::*;
#(
  parameter int                         NUM_REGS   = 2,
  parameter logic [NUM_REGS*CFG_DW-1:0] RESET_FLAT = '0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [CFG_DW-1:0]            addr_i,
  input  logic [CFG_DW-1:0]            wdata_i,
  input  logic                         we_i,
  input  logic                         re_i,
  output logic [CFG_DW-1:0]            rdata_o,
  output logic [NUM_REGS*CFG_DW-1:0]   cfg_o
);
  logic [IDX_W-1:0]  idx;
  logic              in_range;
  logic [CFG_DW-1:0] regs [NUM_REGS];
  logic [CFG_DW-1:0] rd_sel;

  assign idx      = addr_i[IDX_LSB +: IDX_W];
  assign in_range = int'(idx) < NUM_REGS;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           regs[r] <= RESET_FLAT[r*CFG_DW +: CFG_DW];
      else if (we_i && idx == IDX_W'(r))     regs[r] <= wdata_i;
    end
    assign cfg_o[r*CFG_DW +: CFG_DW] = regs[r];

    assert_write_lands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && idx == IDX_W'(r)) |=> (cfg_o[r*CFG_DW +: CFG_DW] == $past(wdata_i)));
  end

  always_comb begin
    rd_sel = '0;
    for (int r = 0; r < NUM_REGS; r++) if (idx == IDX_W'(r)) rd_sel = regs[r];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_sel;
  end

  assert_oob_write_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !in_range) |=> $stable(cfg_o));
  assert_oob_read_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !in_range) |=> (rdata_o == '0));
  assert_read_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/cb_track_gather.sv
module cb_track_gather
  import cb_conn_pkg::*;
#(
  parameter int                    WIDTH      = 32,
  parameter int                    NUM_TRACKS = 5,
  parameter logic [NUM_TRACKS-1:0] FEED_MASK  = '1,
  parameter int                    NUM_IN     = NUM_TRACKS
) (
  input  logic [NUM_TRACKS*WIDTH-1:0] tracks_i,
  output logic [NUM_IN*WIDTH-1:0]     gathered_o
);
  for (genvar k = 0; k < NUM_IN; k++) begin : g_in
    localparam int SRC = nth_set(64'(FEED_MASK), NUM_TRACKS, k);
    assign gathered_o[k*WIDTH +: WIDTH] = tracks_i[SRC*WIDTH +: WIDTH];
  end
endmodule

// File: rtl/cb_out_mux.sv
module cb_out_mux #(
  parameter int WIDTH     = 32,
  parameter int NUM_IN    = 4,
  parameter int SEL_W     = 3,
  parameter int HAS_CONST = 1
) (
  input  logic [NUM_IN*WIDTH-1:0] gathered_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [WIDTH-1:0]        const_i,
  output logic [WIDTH-1:0]        data_o
);
  always_comb begin
    data_o = (HAS_CONST != 0) ? const_i : '0;
    for (int k = 0; k < NUM_IN; k++)
      if (sel_i == SEL_W'(k)) data_o = gathered_i[k*WIDTH +: WIDTH];
  end
endmodule

// File: rtl/cb_conn_box.sv
module cb_conn_box
  import cb_conn_pkg::*;
#(
  parameter int                    WIDTH         = 32,
  parameter int                    NUM_TRACKS    = 5,
  parameter logic [NUM_TRACKS-1:0] FEED_MASK     = 5'b10111,
  parameter int                    HAS_CONST     = 1,
  parameter logic [WIDTH-1:0]      DEFAULT_CONST = 32'hC0DE_1234
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [31:0]                 cfg_addr_i,
  input  logic [31:0]                 cfg_wdata_i,
  input  logic                        cfg_we_i,
  input  logic                        cfg_re_i,
  output logic [31:0]                 cfg_rdata_o,
  input  logic [NUM_TRACKS*WIDTH-1:0] tracks_i,
  output logic [WIDTH-1:0]            data_o
);
  localparam int NUM_IN    = count_ones(64'(FEED_MASK), NUM_TRACKS);
  localparam int HEIGHT    = NUM_IN + HAS_CONST;
  localparam int SEL_W     = sel_width(HEIGHT);
  localparam int CFG_BITS  = SEL_W + ((HAS_CONST != 0) ? WIDTH : 0);
  localparam int NUM_REGS  = (CFG_BITS + CFG_DW - 1) / CFG_DW;
  localparam int CFG_W     = NUM_REGS * CFG_DW;
  localparam int RESET_SEL = NUM_TRACKS - (NUM_TRACKS - NUM_IN) + HAS_CONST - 1;
  localparam logic [CFG_W-1:0] RESET_FLAT = (HAS_CONST != 0)
    ? CFG_W'({DEFAULT_CONST, SEL_W'(RESET_SEL)})
    : CFG_W'(SEL_W'(RESET_SEL));

  logic [CFG_W-1:0]        cfg_flat;
  logic [NUM_IN*WIDTH-1:0] gathered;
  logic [SEL_W-1:0]        sel;
  logic [WIDTH-1:0]        const_val;

  cb_cfg_regs #(
    .NUM_REGS   (NUM_REGS),
    .RESET_FLAT (RESET_FLAT)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .we_i    (cfg_we_i),
    .re_i    (cfg_re_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg_flat)
  );

  cb_track_gather #(
    .WIDTH      (WIDTH),
    .NUM_TRACKS (NUM_TRACKS),
    .FEED_MASK  (FEED_MASK),
    .NUM_IN     (NUM_IN)
  ) u_gather (
    .tracks_i   (tracks_i),
    .gathered_o (gathered)
  );

  assign sel = cfg_flat[SEL_W-1:0];

  if (HAS_CONST != 0) begin : g_const
    assign const_val = cfg_flat[SEL_W +: WIDTH];
  end else begin : g_no_const
    assign const_val = '0;
  end

  cb_out_mux #(
    .WIDTH     (WIDTH),
    .NUM_IN    (NUM_IN),
    .SEL_W     (SEL_W),
    .HAS_CONST (HAS_CONST)
  ) u_mux (
    .gathered_i (gathered),
    .sel_i      (sel),
    .const_i    (const_val),
    .data_o     (data_o)
  );

  for (genvar k = 0; k < NUM_IN; k++) begin : g_chk
    localparam int SRC = nth_set(64'(FEED_MASK), NUM_TRACKS, k);
    assert_track_path_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel == SEL_W'(k)) |-> (data_o == tracks_i[SRC*WIDTH +: WIDTH]));
  end

  assert_fallback_path_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(sel) >= NUM_IN) |-> (data_o == ((HAS_CONST != 0) ? const_val : '0)));
endmodule

// File: tb/cb_conn_box_bench.sv
`timescale 1ns/1ps
module cb_conn_box_bench;
  localparam logic [31:0] DEF = 32'hC0DE_1234;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [31:0]  addr = '0, wdata = '0;
  logic         we = 1'b0, re = 1'b0;
  logic [31:0]  rdata;
  logic [159:0] tracks = '0;
  logic [31:0]  dout;

  logic [31:0]  n_addr = '0, n_wdata = '0;
  logic         n_we = 1'b0, n_re = 1'b0;
  logic [31:0]  n_rdata;
  logic [23:0]  n_tracks = '0;
  logic [7:0]   n_dout;

  int checks = 0, errors = 0;
  logic [31:0] m [2];

  always #2 clk = ~clk;

  cb_conn_box u_cb_conn_box (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .cfg_we_i(we), .cfg_re_i(re), .cfg_rdata_o(rdata),
    .tracks_i(tracks), .data_o(dout));

  cb_conn_box #(
    .WIDTH(8), .NUM_TRACKS(3), .FEED_MASK(3'b111), .HAS_CONST(0),
    .DEFAULT_CONST(8'h00)
  ) u_cb_conn_box_nc (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_addr_i(n_addr), .cfg_wdata_i(n_wdata),
    .cfg_we_i(n_we), .cfg_re_i(n_re), .cfg_rdata_o(n_rdata),
    .tracks_i(n_tracks), .data_o(n_dout));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // inputs 0..3 map to tracks 0,1,2,4 (R1)
  function automatic logic [31:0] exp_out();
    case (m[0][2:0])
      3'd0: return tracks[31:0];
      3'd1: return tracks[63:32];
      3'd2: return tracks[95:64];
      3'd3: return tracks[159:128];
      default: return {m[1][2:0], m[0][31:3]};
    endcase
  endfunction

  task automatic wr(input logic [7:0] idx, input logic [31:0] d);
    @(negedge clk);
    addr = {idx, 24'($urandom)}; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (idx < 8'd2) m[idx[0]] = d;
  endtask

  task automatic rd(input string req, input logic [7:0] idx);
    logic [31:0] e;
    e = (idx < 8'd2) ? m[idx[0]] : 32'h0;
    @(negedge clk);
    addr = {idx, 24'($urandom)}; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    chk(req, rdata, e);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] old0;
    void'($urandom(32'd1234));
    m[0] = {DEF[28:0], 3'd4};
    m[1] = {29'd0, DEF[31:29]};
    tracks   = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111, 32'h0000_0000};
    n_tracks = {8'hC3, 8'hB2, 8'hA1};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R5 reset state, constant selected (R7), fields packed over boundary (R3)
    chk("R5 reset output", dout, DEF);
    chk("R5 reset rdata", rdata, 32'h0);
    rd("R5 reg0 reset", 8'd0);
    rd("R5 R3 reg1 reset", 8'd1);
    chk("R5 nc reset selects input 2", {24'h0, n_dout}, 32'h0000_00C3);

    // R1 R6 each input by select, masked track 3 never appears
    for (int s = 0; s < 4; s++) begin
      wr(8'd0, {m[0][31:3], 3'(s)});
      chk("R1 R6 track select", dout, exp_out());
    end
    chk("R1 input 3 is track 4", dout, 32'h4444_4444);

    // R3 constant split across registers, R7 all fallback selects
    wr(8'd1, 32'hFFFF_FFF5);
    wr(8'd0, {29'h0ABC_DEF1 & 29'h1FFF_FFFF, 3'd4});
    chk("R3 split constant", dout, {3'b101, 29'h0ABC_DEF1});
    for (int s = 5; s < 8; s++) begin
      wr(8'd0, {m[0][31:3], 3'(s)});
      chk("R7 constant fallback", dout, exp_out());
    end

    // R4 out-of-range writes ignored
    wr(8'd2, 32'hDEAD_BEEF);
    wr(8'hFF, 32'h0000_0000);
    rd("R4 reg0 after oob write", 8'd0);
    rd("R4 reg1 after oob write", 8'd1);
    chk("R4 output after oob write", dout, exp_out());

    // R8 oob read, hold, same-cycle write/read
    rd("R8 oob read zero", 8'd7);
    repeat (2) @(negedge clk);
    chk("R8 rdata holds", rdata, 32'h0);
    old0 = m[0];
    @(negedge clk);
    addr = 32'h0000_0000; wdata = 32'h1234_5670; we = 1'b1; re = 1'b1;
    @(negedge clk);
    we = 1'b0; re = 1'b0; m[0] = 32'h1234_5670;
    chk("R8 read sees old value", rdata, old0);
    rd("R8 read after write", 8'd0);

    // R7 R6 no-constant instance
    @(negedge clk);
    n_addr = 32'h0000_0000; n_wdata = 32'h3; n_we = 1'b1;
    @(negedge clk);
    n_we = 1'b0;
    chk("R7 nc fallback zero", {24'h0, n_dout}, 32'h0);
    n_wdata = 32'h1; n_we = 1'b1;
    @(negedge clk);
    n_we = 1'b0;
    chk("R6 nc input 1", {24'h0, n_dout}, 32'h0000_00B2);

    // random mix (R2 R4 R6 R7 R8)
    for (int i = 0; i < 400; i++) begin
      tracks = {$urandom, $urandom, $urandom, $urandom, $urandom};
      wr(8'($urandom_range(0, 3)), $urandom);
      chk("R2 R6 R7 random output", dout, exp_out());
      if (i % 4 == 0) rd("R4 R8 random readback", 8'($urandom_range(0, 3)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule